// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with APB Register Access

This block gathers a configurable number of level-sensitive interrupt request lines and folds them into one interrupt line towards a processor. Each request line is brought into the local clock domain through a two-stage synchronizer. It then passes two gates before it reaches the output: an enable bit that lets software admit the line, and a mask bit that lets software block it for a while. The gated result for every line can be read back as a pending-status word. The output interrupt is high whenever any pending-status bit is high.

Software reaches the block over a zero-wait-state APB slave port. Per-line state is grouped into 32-bit words. The lower word covers lines 0 to 31 and the upper word, four bytes higher, covers lines 32 to 63. The number of lines is fixed at build time between 2 and 64. Storage for lines that do not exist is left out, so those bit positions always read back as zero. Software can therefore learn the line count by writing all ones to the enable words and reading them back. Pending status clears only when the request line itself drops, because no clear register exists.

Top module: `irqc_top`

## Requirements
- R1: The enable words are at byte offset 0x00 (lines 0-31) and 0x04 (lines 32-63). They are read/write, and bit positions at or above NUM_SRC always read 0, even after all ones are written.
- R2: The mask words are at byte offset 0x08 (lines 0-31) and 0x0C (lines 32-63). They are read/write with the same rule for unimplemented bits. A mask bit of 1 blocks its line and a 0 passes it.
- R3: The pending-status words are at byte offset 0x30 (lines 0-31) and 0x34 (lines 32-63). Bit n reads as synchronized line n AND enable n AND NOT mask n.
- R4: irq_o is 1 exactly when at least one pending-status bit is 1.
- R5: A change on src_i reaches pending status and irq_o after the second rising clock edge following the change, and not before.
- R6: After reset all enable and mask bits read 0 and irq_o is 0.
- R7: Pending status is level-sensitive. It stays 1 while its line stays high and drops two edges after the line drops, without any software action.
- R8: Writes to the status offsets and to unmapped offsets change no register. Reads of unmapped offsets return 0.
- R9: pready_o is always 1 and pslverr_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write (1) or read (0) |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data, 0 when not selected |
| pready_o | output | 1 | Always ready |
| pslverr_o | output | 1 | Never signals an error |
| src_i | input | NUM_SRC | Level-sensitive interrupt request lines |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The assertions assume that APB transfers follow the protocol: a setup cycle with psel_i alone, then a single access cycle with penable_i. They also assume that src_i is held stable across clock edges, so that the two-edge latency can be stated exactly against $past of the inputs. The bench drives the APB and the request lines only on falling clock edges, always uses a full setup-then-access pair, and holds each request pattern for several cycles before it reads status. This keeps every sample inside those assumptions.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned WORD_W = 32;

  // word index = byte offset >> 2
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN_LO,
    SEL_EN_HI,
    SEL_MK_LO,
    SEL_MK_HI,
    SEL_ST_LO,
    SEL_ST_HI
  } reg_sel_e;

  function automatic reg_sel_e decode_word(input logic [5:0] widx);
    case (widx)
      6'd0:    decode_word = SEL_EN_LO;
      6'd1:    decode_word = SEL_EN_HI;
      6'd2:    decode_word = SEL_MK_LO;
      6'd3:    decode_word = SEL_MK_HI;
      6'd12:   decode_word = SEL_ST_LO;
      6'd13:   decode_word = SEL_ST_HI;
      default: decode_word = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [WORD_W-1:0]  pwdata_i,
  output reg_sel_e           sel_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [5:0] widx;
  logic       wr_acc;
  logic       wr_en_lo, wr_en_hi, wr_mk_lo, wr_mk_hi;
  logic [NUM_SRC-1:0] en_q, mask_q;

  // upper address bits beyond the decoded window force a miss
  always_comb begin
    widx = '0;
    for (int i = 0; i < 6; i++) begin
      if (i + 2 < ADDR_W) widx[i] = paddr_i[i+2];
    end
    sel_o = decode_word(widx);
    for (int i = 8; i < ADDR_W; i++) begin
      if (paddr_i[i]) sel_o = SEL_NONE;
    end
  end

  assign wr_acc   = psel_i & penable_i & pwrite_i;
  assign wr_en_lo = wr_acc & (sel_o == SEL_EN_LO);
  assign wr_en_hi = wr_acc & (sel_o == SEL_EN_HI);
  assign wr_mk_lo = wr_acc & (sel_o == SEL_MK_LO);
  assign wr_mk_hi = wr_acc & (sel_o == SEL_MK_HI);

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam bit HI = (n >= WORD_W);
    logic wr_en, wr_mk;
    if (HI) begin : g_hi
      assign wr_en = wr_en_hi;
      assign wr_mk = wr_mk_hi;
    end else begin : g_lo
      assign wr_en = wr_en_lo;
      assign wr_mk = wr_mk_lo;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[n]   <= 1'b0;
        mask_q[n] <= 1'b0;
      end else begin
        if (wr_en) en_q[n]   <= pwdata_i[n % WORD_W];
        if (wr_mk) mask_q[n] <= pwdata_i[n % WORD_W];
      end
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic [NUM_SRC-1:0] src_sync_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic               irq_o
);
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_gate
    assign status_o[n] = src_sync_i[n] & en_i[n] & ~mask_i[n];
  end
  assign irq_o = |status_o;
endmodule

// File: rtl/irqc_rdata.sv
module irqc_rdata
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic               psel_i,
  input  reg_sel_e           sel_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [WORD_W-1:0]  rdata_o
);
  localparam int unsigned FULL_W = 2 * WORD_W;

  logic [FULL_W-1:0] en_w, mask_w, st_w;

  always_comb begin
    en_w   = '0;
    mask_w = '0;
    st_w   = '0;
    en_w[NUM_SRC-1:0]   = en_i;
    mask_w[NUM_SRC-1:0] = mask_i;
    st_w[NUM_SRC-1:0]   = status_i;
  end

  always_comb begin
    rdata_o = '0;
    if (psel_i) begin
      unique case (sel_i)
        SEL_EN_LO: rdata_o = en_w[WORD_W-1:0];
        SEL_EN_HI: rdata_o = en_w[FULL_W-1:WORD_W];
        SEL_MK_LO: rdata_o = mask_w[WORD_W-1:0];
        SEL_MK_HI: rdata_o = mask_w[FULL_W-1:WORD_W];
        SEL_ST_LO: rdata_o = st_w[WORD_W-1:0];
        SEL_ST_HI: rdata_o = st_w[FULL_W-1:WORD_W];
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [31:0]        pwdata_i,
  output logic [31:0]        prdata_o,
  output logic               pready_o,
  output logic               pslverr_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  localparam int unsigned SYNC_STAGES = 2;

  reg_sel_e           sel;
  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] status;

  irqc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_i),
    .q_o    (src_sync)
  );

  irqc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .pwdata_i  (pwdata_i),
    .sel_o     (sel),
    .en_o      (en_q),
    .mask_o    (mask_q)
  );

  irqc_status #(.NUM_SRC(NUM_SRC)) u_status (
    .src_sync_i (src_sync),
    .en_i       (en_q),
    .mask_i     (mask_q),
    .status_o   (status),
    .irq_o      (irq_o)
  );

  irqc_rdata #(.NUM_SRC(NUM_SRC)) u_rdata (
    .psel_i   (psel_i),
    .sel_i    (sel),
    .en_i     (en_q),
    .mask_i   (mask_q),
    .status_i (status),
    .rdata_o  (prdata_o)
  );

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               psel_i,
  input logic               penable_i,
  input logic               pwrite_i,
  input logic [ADDR_W-1:0]  paddr_i,
  input logic [31:0]        prdata_o,
  input logic [NUM_SRC-1:0] src_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] mask_q
);
  localparam logic [31:0] HI_IMPL =
    (NUM_SRC > 32) ? (32'hFFFF_FFFF >> (64 - NUM_SRC)) : 32'h0;
  localparam logic [ADDR_W-1:0] A_EN_HI = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_MK_HI = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_ST_LO = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_ST_HI = ADDR_W'(8'h34);

  // R1
  a_r1_en_hi_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && paddr_i == A_EN_HI) |-> ((prdata_o & ~HI_IMPL) == 32'h0));

  // R2
  a_r2_mk_hi_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && paddr_i == A_MK_HI) |-> ((prdata_o & ~HI_IMPL) == 32'h0));

  // R3
  a_r3_irq_needs_gate_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((en_q & ~mask_q) != '0));

  // R5
  a_r5_two_stage_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (($past(src_i, 2) & en_q & ~mask_q) != '0));

  // R7
  a_r7_quiet_lines_drop_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0 && $past(src_i) == '0) |=> !irq_o);

  // R8
  a_r8_status_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && pwrite_i && (paddr_i == A_ST_LO || paddr_i == A_ST_HI))
      |=> ($stable(en_q) && $stable(mask_q)));
endmodule

bind irqc_top irqc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .psel_i    (psel_i),
  .penable_i (penable_i),
  .pwrite_i  (pwrite_i),
  .paddr_i   (paddr_i),
  .prdata_o  (prdata_o),
  .src_i     (src_i),
  .irq_o     (irq_o),
  .en_q      (en_q),
  .mask_q    (mask_q)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;
  localparam int NUM_SRC = 40;
  localparam int ADDR_W  = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0]  paddr = '0;
  logic [31:0]        pwdata = '0;
  logic [31:0]        prdata;
  logic               pready, pslverr;
  logic [NUM_SRC-1:0] src = '0;
  logic               irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqc_top #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .src_i(src), .irq_o(irq)
  );

  // {enable, mask, src, expected status}
  typedef struct packed {
    logic [63:0] en;
    logic [63:0] mk;
    logic [63:0] sr;
    logic [63:0] st;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{64'h00FF_FFFF_FFFF, 64'h0,            64'h1,            64'h1},
    '{64'h00FF_FFFF_FFFF, 64'h1,            64'h1,            64'h0},
    '{64'h00F0_0000_0000, 64'h0,            64'h00FF_FFFF_FFFF, 64'h00F0_0000_0000},
    '{64'h0,              64'h0,            64'h00FF_FFFF_FFFF, 64'h0},
    '{64'h00FF_0000_FFFF, 64'h000F_0000_FF00, 64'h0080_8000_8001, 64'h0080_0000_0001},
    '{64'h0080_0000_0000, 64'h0080_0000_0000, 64'h0080_0000_0000, 64'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: reset state
    apb_rd(8'h00, rd); chk("R6 en_lo", rd, 32'h0);
    apb_rd(8'h04, rd); chk("R6 en_hi", rd, 32'h0);
    apb_rd(8'h08, rd); chk("R6 mk_lo", rd, 32'h0);
    apb_rd(8'h0C, rd); chk("R6 mk_hi", rd, 32'h0);
    chk("R6 irq", {31'h0, irq}, 32'h0);
    // R9
    chk("R9 ready/err", {30'h0, pready, pslverr}, 32'h2);

    // table walk: R3, R4
    for (int v = 0; v < 6; v++) begin
      apb_wr(8'h00, VECS[v].en[31:0]);
      apb_wr(8'h04, VECS[v].en[63:32]);
      apb_wr(8'h08, VECS[v].mk[31:0]);
      apb_wr(8'h0C, VECS[v].mk[63:32]);
      @(negedge clk);
      src = VECS[v].sr[NUM_SRC-1:0];
      repeat (3) @(negedge clk);
      apb_rd(8'h30, rd); chk("R3 st_lo", rd, VECS[v].st[31:0]);
      apb_rd(8'h34, rd); chk("R3 st_hi", rd, VECS[v].st[63:32]);
      chk("R4 irq", {31'h0, irq}, {31'h0, |VECS[v].st});
    end
    src = '0;

    // R1 / R2: unimplemented bits read zero
    apb_wr(8'h00, 32'hFFFF_FFFF);
    apb_wr(8'h04, 32'hFFFF_FFFF);
    apb_wr(8'h08, 32'hFFFF_FFFF);
    apb_wr(8'h0C, 32'hFFFF_FFFF);
    apb_rd(8'h00, rd); chk("R1 en_lo", rd, 32'hFFFF_FFFF);
    apb_rd(8'h04, rd); chk("R1 en_hi count", rd, 32'h0000_00FF);
    apb_rd(8'h08, rd); chk("R2 mk_lo", rd, 32'hFFFF_FFFF);
    apb_rd(8'h0C, rd); chk("R2 mk_hi count", rd, 32'h0000_00FF);

    // R8: status and unmapped writes ignored
    apb_wr(8'h30, 32'h0);
    apb_wr(8'h34, 32'h0);
    apb_wr(8'h10, 32'h0);
    apb_rd(8'h00, rd); chk("R8 en_lo kept", rd, 32'hFFFF_FFFF);
    apb_rd(8'h0C, rd); chk("R8 mk_hi kept", rd, 32'h0000_00FF);
    apb_rd(8'h10, rd); chk("R8 unmapped read", rd, 32'h0);
    apb_rd(8'h2C, rd); chk("R8 unmapped read2", rd, 32'h0);

    // R5: two-edge latency on line 0
    apb_wr(8'h08, 32'h0);
    apb_wr(8'h0C, 32'h0);
    apb_wr(8'h00, 32'h1);
    apb_wr(8'h04, 32'h0);
    @(negedge clk);
    src[0] = 1'b1;
    @(negedge clk);
    chk("R5 irq after 1 edge", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R5 irq after 2 edges", {31'h0, irq}, 32'h1);

    // R7: level held, then released
    repeat (5) @(negedge clk);
    chk("R7 held", {31'h0, irq}, 32'h1);
    src[0] = 1'b0;
    @(negedge clk);
    chk("R7 drop after 1 edge", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R7 drop after 2 edges", {31'h0, irq}, 32'h0);
    apb_rd(8'h30, rd); chk("R7 status cleared", rd, 32'h0);

    // R2: masking a pending line removes it at once
    src[0] = 1'b1;
    repeat (3) @(negedge clk);
    apb_wr(8'h08, 32'h1);
    chk("R2 mask blocks", {31'h0, irq}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule